// File: doc/BRIEF.md
# Endpoint Configuration Header Registers (Identity, Command, Memory Window)

This block sits on the endpoint side of a serial expansion link. It answers configuration reads and writes for three dwords of a type-0 configuration header: the identifier dword, the command dword and the first base address register. Accesses arrive on a dword-indexed request port with a per-byte write strobe. Read data comes back one cycle after the request. Writes complete in the cycle that presents them.

The base address register describes one 32-bit, non-prefetchable memory window. Its size is a power of two set by a parameter. Address bits below the window size are hardwired to zero. Host software therefore learns the window size by writing all ones and reading back the mask. It then programs a base aligned to that size. The block drives the programmed base and the three command enable bits out to the application. It also flags incoming memory addresses that fall inside the window while memory decoding is enabled.

Top module: `ebc_endpoint_regs`

## Requirements
- R1: While reset is asserted, and directly after it, the command enables are zero, the window base is zero and `cfg_rd_valid` is low. A read of dword 1 or dword 4 after reset returns zero.
- R2: A read of dword 0 returns the device identifier in bits 31:16 and the vendor identifier in bits 15:0. The vendor identifier never reads as 16'hFFFF. Writes to dword 0 have no effect.
- R3: Dword 1 holds the command enables: bit 0 enables I/O, bit 1 enables memory decoding and bit 2 enables bus mastering. These bits are written only when strobe bit 0 is set. All other bits of dword 1 read as zero. The outputs `io_en`, `mem_en` and `bus_master_en` follow bits 0, 1 and 2.
- R4: After all ones are written to dword 4 with every strobe bit set, a read returns ~(2^BAR_SIZE_LOG2 - 1). For the default window of 16 MB this value is 32'hFF000000.
- R5: Bits 3:0 of dword 4 always read as zero, which marks a 32-bit, non-prefetchable memory window. Writes to any bit below BAR_SIZE_LOG2 are ignored.
- R6: On a write to dword 4, strobe bit k gates bits 8k+7:8k. A byte lane whose strobe is clear keeps its old value.
- R7: A base aligned to the window size, such as 32'h1C000000, reads back unchanged from dword 4 and appears on `bar_base`.
- R8: `mem_hit` is high exactly when `mem_en` is set and bits 31:BAR_SIZE_LOG2 of `mem_addr` equal the same bits of the programmed base.
- R9: Reads of any other dword index return zero. Writes to those indices change no register.
- R10: A read request produces `cfg_rd_valid` high, with its data, on the cycle after the request. A write request or an idle cycle leaves `cfg_rd_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration request present this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | IDX_W | Dword index into the configuration header |
| cfg_be | input | 4 | Per-byte write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after the read request |
| cfg_rd_data | output | 32 | Read data |
| io_en | output | 1 | I/O decode enable (command bit 0) |
| mem_en | output | 1 | Memory decode enable (command bit 1) |
| bus_master_en | output | 1 | Bus master enable (command bit 2) |
| bar_base | output | 32 | Programmed window base, with the low bits zero |
| mem_addr | input | 32 | Address of an incoming memory request |
| mem_hit | output | 1 | Incoming address falls in the enabled window |

## Verification
The bench first runs the sizing probe with all ones and then programs an aligned base. A design that stored the low bits would return a mask with stray set bits, or a nonzero type field. Partial strobes on the window register catch a design that ignores lane gating, since such a design overwrites bytes that should keep their old value. Writes to the identifier dword and to unimplemented indices catch decode aliasing, because a design with that fault would corrupt the command or base register. The hit checks probe addresses just inside and just outside the window, with memory decoding both on and off. A wrong compare width or a missing enable gate then shows up as a false hit or a missed hit.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   localparam int unsigned DW_W = 32;
   localparam int unsigned BE_W = DW_W / 8;

   // dword indices inside the type-0 header that the block decodes
   localparam int unsigned ID_DW  = 0;
   localparam int unsigned CMD_DW = 1;
   localparam int unsigned BAR_DW = 4;

   // memory window type field: memory space, 32-bit, non-prefetchable
   localparam logic [3:0] BAR_TYPE_MEM32 = 4'b0000;

   localparam int unsigned CMD_W = 3;

   // field order matches the command bit positions (bit 2 .. bit 0)
   typedef struct packed {
      logic bus_master;
      logic mem;
      logic io;
   } cmd_t;

   function automatic logic [DW_W-1:0] win_mask(input int unsigned size_log2);
      logic [DW_W-1:0] m;
      m = '1;
      m = m << size_log2;
      return m;
   endfunction

endpackage

// File: rtl/ebc_cmd_reg.sv
module ebc_cmd_reg
   import ebc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             lane_en,
   input  logic [CMD_W-1:0] wr_bits,
   output cmd_t             cmd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en && lane_en) begin
         cmd_q <= cmd_t'(wr_bits);
      end
   end

endmodule

// File: rtl/ebc_bar_reg.sv
module ebc_bar_reg
   import ebc_pkg::*;
#(
   parameter int unsigned BAR_SIZE_LOG2 = 24
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [BE_W-1:0] wr_be,
   input  logic [DW_W-1:0] wr_data,
   output logic [DW_W-1:0] bar_q
);

   localparam logic [DW_W-1:0] WMASK = win_mask(BAR_SIZE_LOG2);

   logic [7:0] lane_q [BE_W];

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      localparam logic [7:0] LMASK = WMASK[8*g +: 8];
      if (LMASK == 8'h00) begin : g_fixed
         // lane lies wholly below the window size: hardwired zero
         assign lane_q[g] = 8'h00;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[g] <= 8'h00;
            end else if (wr_en && wr_be[g]) begin
               lane_q[g] <= (lane_q[g] & ~LMASK) | (wr_data[8*g +: 8] & LMASK);
            end
         end
      end
      assign bar_q[8*g +: 8] = lane_q[g];
   end

endmodule

// File: rtl/ebc_cfg_rdport.sv
module ebc_cfg_rdport
   import ebc_pkg::*;
#(
   parameter int unsigned IDX_W     = 10,
   parameter logic [15:0] VENDOR_ID = 16'h1AB5,
   parameter logic [15:0] DEVICE_ID = 16'h7E21
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [IDX_W-1:0] rd_idx,
   input  cmd_t             cmd,
   input  logic [DW_W-1:0]  bar_q,
   output logic             rd_valid,
   output logic [DW_W-1:0]  rd_data
);

   logic [DW_W-1:0] sel_data;

   always_comb begin
      sel_data = '0;
      if (rd_idx == IDX_W'(ID_DW)) begin
         sel_data = {DEVICE_ID, VENDOR_ID};
      end else if (rd_idx == IDX_W'(CMD_DW)) begin
         sel_data = {{(DW_W-CMD_W){1'b0}}, cmd};
      end else if (rd_idx == IDX_W'(BAR_DW)) begin
         sel_data = {bar_q[DW_W-1:4], BAR_TYPE_MEM32};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_data <= sel_data;
         end
      end
   end

endmodule

// File: rtl/ebc_mem_decode.sv
module ebc_mem_decode
   import ebc_pkg::*;
#(
   parameter int unsigned BAR_SIZE_LOG2 = 24
)(
   input  logic            mem_en,
   input  logic [DW_W-1:0] bar_q,
   input  logic [DW_W-1:0] mem_addr,
   output logic            mem_hit
);

   localparam logic [DW_W-1:0] WMASK = win_mask(BAR_SIZE_LOG2);

   always_comb begin
      mem_hit = mem_en && ((mem_addr & WMASK) == (bar_q & WMASK));
   end

endmodule

// File: rtl/ebc_endpoint_regs.sv
module ebc_endpoint_regs
   import ebc_pkg::*;
#(
   parameter int unsigned IDX_W         = 10,
   parameter int unsigned BAR_SIZE_LOG2 = 24,
   parameter logic [15:0] VENDOR_ID     = 16'h1AB5,
   parameter logic [15:0] DEVICE_ID     = 16'h7E21
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic             cfg_write,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [3:0]       cfg_be,
   input  logic [31:0]      cfg_wdata,
   output logic             cfg_rd_valid,
   output logic [31:0]      cfg_rd_data,
   output logic             io_en,
   output logic             mem_en,
   output logic             bus_master_en,
   output logic [31:0]      bar_base,
   input  logic [31:0]      mem_addr,
   output logic             mem_hit
);

   if (BAR_SIZE_LOG2 < 7 || BAR_SIZE_LOG2 > 31) begin : g_bad_size
      $error("BAR_SIZE_LOG2 must lie in 7..31");
   end
   if (IDX_W < 3) begin : g_bad_idx
      $error("IDX_W too narrow to reach the window register");
   end
   if (VENDOR_ID == 16'hFFFF) begin : g_bad_vid
      $error("VENDOR_ID of all ones marks an absent function");
   end

   logic wr_req;
   logic rd_req;
   logic cmd_sel;
   logic bar_sel;
   cmd_t cmd_q;
   logic [DW_W-1:0] bar_q;

   assign wr_req  = cfg_valid && cfg_write;
   assign rd_req  = cfg_valid && !cfg_write;
   assign cmd_sel = (cfg_idx == IDX_W'(CMD_DW));
   assign bar_sel = (cfg_idx == IDX_W'(BAR_DW));

   ebc_cmd_reg u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_req && cmd_sel),
      .lane_en (cfg_be[0]),
      .wr_bits (cfg_wdata[CMD_W-1:0]),
      .cmd_q   (cmd_q)
   );

   ebc_bar_reg #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_bar (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_req && bar_sel),
      .wr_be   (cfg_be),
      .wr_data (cfg_wdata),
      .bar_q   (bar_q)
   );

   ebc_cfg_rdport #(
      .IDX_W     (IDX_W),
      .VENDOR_ID (VENDOR_ID),
      .DEVICE_ID (DEVICE_ID)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .rd_idx   (cfg_idx),
      .cmd      (cmd_q),
      .bar_q    (bar_q),
      .rd_valid (cfg_rd_valid),
      .rd_data  (cfg_rd_data)
   );

   ebc_mem_decode #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_dec (
      .mem_en   (cmd_q.mem),
      .bar_q    (bar_q),
      .mem_addr (mem_addr),
      .mem_hit  (mem_hit)
   );

   assign io_en         = cmd_q.io;
   assign mem_en        = cmd_q.mem;
   assign bus_master_en = cmd_q.bus_master;
   assign bar_base      = bar_q;

endmodule

// File: rtl/ebc_endpoint_regs_chk.sv
module ebc_endpoint_regs_chk #(
   parameter int unsigned IDX_W         = 10,
   parameter int unsigned BAR_SIZE_LOG2 = 24
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_valid,
   input logic             cfg_write,
   input logic [IDX_W-1:0] cfg_idx,
   input logic [3:0]       cfg_be,
   input logic             cfg_rd_valid,
   input logic [31:0]      cfg_rd_data,
   input logic             io_en,
   input logic             mem_en,
   input logic             bus_master_en,
   input logic [31:0]      bar_base,
   input logic             mem_hit
);

   logic cmd_wr;
   logic bar_wr;
   assign cmd_wr = cfg_valid && cfg_write && (cfg_idx == IDX_W'(1)) && cfg_be[0];
   assign bar_wr = cfg_valid && cfg_write && (cfg_idx == IDX_W'(4)) && (cfg_be != 4'b0000);

   // R2
   a_r2_vendor_present: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_valid && $past(cfg_idx == IDX_W'(0))) |-> (cfg_rd_data[15:0] != 16'hFFFF));

   // R3
   a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable({bus_master_en, mem_en, io_en}));

   // R5
   a_r5_type_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_valid && $past(cfg_idx == IDX_W'(4))) |-> (cfg_rd_data[3:0] == 4'b0000));

   // R6
   a_r6_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bar_wr |=> $stable(bar_base));

   // R8
   a_r8_hit_needs_mem_en: assert property (@(posedge clk) disable iff (!rst_n)
      mem_hit |-> mem_en);

   // R10
   a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write) |=> cfg_rd_valid);

   // R10
   a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && !cfg_write) |=> !cfg_rd_valid);

endmodule

bind ebc_endpoint_regs ebc_endpoint_regs_chk #(
   .IDX_W         (IDX_W),
   .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_valid     (cfg_valid),
   .cfg_write     (cfg_write),
   .cfg_idx       (cfg_idx),
   .cfg_be        (cfg_be),
   .cfg_rd_valid  (cfg_rd_valid),
   .cfg_rd_data   (cfg_rd_data),
   .io_en         (io_en),
   .mem_en        (mem_en),
   .bus_master_en (bus_master_en),
   .bar_base      (bar_base),
   .mem_hit       (mem_hit)
);

// File: tb/ebc_endpoint_regs_tb.sv
module ebc_endpoint_regs_tb;

   localparam int unsigned IDX_W = 10;
   localparam int unsigned SZ    = 24;
   localparam logic [15:0] VID   = 16'h1AB5;
   localparam logic [15:0] DID   = 16'h7E21;
   localparam logic [31:0] WMASK = 32'hFFFF_FFFF << SZ;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic             cfg_write = 1'b0;
   logic [IDX_W-1:0] cfg_idx = '0;
   logic [3:0]       cfg_be = '0;
   logic [31:0]      cfg_wdata = '0;
   logic             cfg_rd_valid;
   logic [31:0]      cfg_rd_data;
   logic             io_en, mem_en, bus_master_en;
   logic [31:0]      bar_base;
   logic [31:0]      mem_addr = '0;
   logic             mem_hit;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   logic [2:0]  m_cmd = '0;
   logic [31:0] m_bar = '0;

   always #2 clk = ~clk;

   ebc_endpoint_regs #(
      .IDX_W(IDX_W), .BAR_SIZE_LOG2(SZ), .VENDOR_ID(VID), .DEVICE_ID(DID)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
      .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data),
      .io_en(io_en), .mem_en(mem_en), .bus_master_en(bus_master_en),
      .bar_base(bar_base), .mem_addr(mem_addr), .mem_hit(mem_hit)
   );

   function automatic logic [31:0] exp_read(input logic [IDX_W-1:0] idx);
      if (idx == 0) return {DID, VID};
      if (idx == 1) return {29'd0, m_cmd};
      if (idx == 4) return m_bar;
      return 32'd0;
   endfunction

   function automatic logic exp_hit(input logic [31:0] a);
      return m_cmd[1] && ((a & WMASK) == m_bar);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [IDX_W-1:0] idx, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
      chk("R10 no valid after write", {31'd0, cfg_rd_valid}, 32'd0);
      if (idx == 1 && be[0]) m_cmd = d[2:0];
      if (idx == 4) begin
         for (int k = 0; k < 4; k++) begin
            if (be[k]) begin
               logic [31:0] lm;
               lm = (32'hFF << (8*k)) & WMASK;
               m_bar = (m_bar & ~lm) | (d & lm);
            end
         end
      end
   endtask

   task automatic cfg_rd(input logic [IDX_W-1:0] idx, output logic [31:0] d);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_idx = idx; cfg_be = $urandom;
      @(negedge clk);
      cfg_valid = 1'b0;
      chk("R10 valid after read", {31'd0, cfg_rd_valid}, 32'd1);
      d = cfg_rd_data;
   endtask

   task automatic rd_chk(input string req, input logic [IDX_W-1:0] idx);
      logic [31:0] d;
      cfg_rd(idx, d);
      chk(req, d, exp_read(idx));
   endtask

   task automatic hit_chk(input string req, input logic [31:0] a);
      @(negedge clk);
      mem_addr = a;
      #1;
      chk(req, {31'd0, mem_hit}, {31'd0, exp_hit(a)});
   endtask

   task automatic out_chk(input string req);
      chk(req, {29'd0, bus_master_en, mem_en, io_en}, {29'd0, m_cmd});
      chk(req, bar_base, m_bar);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog R1-R10 act=timeout exp=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 rd_valid in reset", {31'd0, cfg_rd_valid}, 32'd0);
      out_chk("R1 outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      out_chk("R1 outputs after reset");
      rd_chk("R1 command after reset", 1);
      rd_chk("R1 window after reset", 4);

      // R2 identifier, read-only
      rd_chk("R2 identifier", 0);
      cfg_rd(0, d);
      chk("R2 vendor not all ones", {31'd0, d[15:0] == 16'hFFFF}, 32'd0);
      cfg_wr(0, 4'hF, 32'h0);
      rd_chk("R2 identifier after write", 0);

      // R4 sizing probe
      cfg_wr(4, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(4, d);
      chk("R4 size mask", d, 32'hFF00_0000);
      // R5 low bits and type
      chk("R5 type bits", {28'd0, d[3:0]}, 32'd0);

      // R7 base programming
      cfg_wr(4, 4'hF, 32'h1C00_000F);
      cfg_rd(4, d);
      chk("R7 base readback", d, 32'h1C00_0000);
      chk("R7 bar_base port", bar_base, 32'h1C00_0000);

      // R6 byte lanes
      cfg_wr(4, 4'b0111, 32'hFFFF_FFFF);
      chk("R6 lanes off keep base", bar_base, 32'h1C00_0000);
      cfg_wr(4, 4'b1000, 32'hAB12_3456);
      chk("R6 top lane written", bar_base, 32'hAB00_0000);
      cfg_wr(4, 4'hF, 32'h1C00_0000);

      // R3 command
      cfg_wr(1, 4'b0001, 32'hFFFF_FFFF);
      rd_chk("R3 command all set", 1);
      out_chk("R3 enables out");
      cfg_wr(1, 4'b1110, 32'h0);
      rd_chk("R3 strobe0 clear ignored", 1);
      cfg_wr(1, 4'b0001, 32'h0000_0002);
      rd_chk("R3 memory only", 1);
      out_chk("R3 enables out 2");

      // R8 hits
      hit_chk("R8 inside low edge", 32'h1C00_0000);
      hit_chk("R8 inside high edge", 32'h1CFF_FFFF);
      hit_chk("R8 just above", 32'h1D00_0000);
      hit_chk("R8 just below", 32'h1BFF_FFFF);
      cfg_wr(1, 4'b0001, 32'h5);
      hit_chk("R8 mem disabled", 32'h1C00_1234);

      // R9 unimplemented offsets
      rd_chk("R9 dword 2", 2);
      rd_chk("R9 dword 5", 5);
      rd_chk("R9 top index", 10'h3FF);
      cfg_wr(2, 4'hF, 32'hFFFF_FFFF);
      cfg_wr(5, 4'hF, 32'hFFFF_FFFF);
      rd_chk("R9 command untouched", 1);
      rd_chk("R9 window untouched", 4);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [IDX_W-1:0] idx;
         int sel;
         sel = $urandom_range(0, 5);
         case (sel)
            0: idx = 0;
            1, 2: idx = 1;
            3, 4: idx = 4;
            default: idx = IDX_W'($urandom);
         endcase
         if ($urandom_range(0, 1) == 1) begin
            cfg_wr(idx, 4'($urandom), $urandom);
            out_chk("R3 R6 random outputs");
         end else begin
            rd_chk("R2 R3 R4 R9 random read", idx);
         end
         if ($urandom_range(0, 1) == 1)
            hit_chk("R8 random near", m_bar | ($urandom & ~WMASK));
         else
            hit_chk("R8 random far", $urandom);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule